// File: doc/BRIEF.md
# DMA Bus Master Cycle Sequencer

This block runs the host-bus side of a block DMA transfer. Given a 32-bit start address, a word count and a direction, it steps through one bus cycle per word. Each cycle passes through a fixed series of bus-clock states: the address is set up, then the active-low read or write strobe is driven, and wait states follow until the slave reports ready. The strobe is then released and the address and count advance.

Only the lower 16 address bits are driven for every cycle. The upper half is offered to external logic by a one-cycle latch-enable pulse. That pulse is issued before the first cycle of every block. After that it is issued only when the address step carries out of the lower half, so external logic never holds a stale upper address.

The slave's ready line may change at any time and is passed through a synchronizer inside the block. The step size depends on the bus width, and the width is taken from a configuration pin at the moment reset is released.

Top module: `dma_cycle_seq`

## Requirements
- R1: While reset is held and right after it, both strobes are high (inactive), the latch-enable pulse `extLatch` is 0 and `done` is 0.
- R2: A start request seen while idle with a nonzero word count produces one `extLatch` cycle before the first strobe. During that cycle `addrHigh` equals bits 31:16 of the start address.
- R3: For each word, `addrLow` shows the current lower address half while the strobe is asserted. `dirRead`=1 selects `readStrobeN` and `dirRead`=0 selects `writeStrobeN`. The strobe is asserted for exactly one clock when the synchronized ready is already low, and the two strobes are never low together.
- R4: `readyN` is asynchronous and active low, and passes through a two-stage synchronizer. A cycle whose slave first drives `readyN` low after the strobe has been low for W clocks (W ≥ 1) keeps the strobe low for W+2 clocks in total.
- R5: After each cycle the address grows by 2 when the captured width is 16-bit (`busWide`=1) and by 1 when it is 8-bit (`busWide`=0).
- R6: After the first cycle, `extLatch` is pulsed again only when an address step carries out of bit 15. During that pulse `addrHigh` shows the new upper half, and the pulse comes before the next strobe.
- R7: The width is the value of `busWide` at the last clock before reset is released. Later changes on `busWide` do not alter the step.
- R8: Exactly `wordCount` strobe cycles take place. `done` is high for one clock, in the clock after the final strobe release.
- R9: A start request is ignored while a block is in progress, and also when the word count is 0. In the zero-count case no strobe, no `extLatch` and no `done` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset; width captured on release |
| busWide | input | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| startReq | input | 1 | Start a block transfer |
| startAddr | input | 32 | First address of the block |
| wordCount | input | 16 | Number of bus cycles in the block |
| dirRead | input | 1 | 1 = read cycles, 0 = write cycles |
| readyN | input | 1 | Asynchronous active-low slave ready |
| readStrobeN | output | 1 | Active-low read strobe |
| writeStrobeN | output | 1 | Active-low write strobe |
| addrLow | output | 16 | Lower address half |
| addrHigh | output | 16 | Upper address half, for external latching |
| extLatch | output | 1 | Pulse telling external logic to latch `addrHigh` |
| busy | output | 1 | A block is in progress |
| done | output | 1 | One-clock pulse after the last cycle |

## Verification
The hardest case to reach is a carry out of the lower address half in the middle of a block while wait states are being inserted. That case needs the block to re-enter the latch state between two cycles, and the slave's ready line must be re-armed across that extra state. Directed blocks start a few steps below a 64K boundary in both widths. Random blocks place a quarter of their start addresses just under such a boundary and give every cycle a random wait length. A bench model predicts every latch pulse, every address and the exact strobe length from the ready timing it drives.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_XAL, ST_T1, ST_T2, ST_TW, ST_T3
  } tState_e;

  typedef struct packed {
    logic load;
    logic advance;
  } ctrlCmd_t;

  typedef struct packed {
    logic lastWord;
    logic crossLow;
    logic readyOk;
    logic countZero;
  } dpStat_t;
endpackage

// File: rtl/dma_seq_datapath.sv
module dma_seq_datapath
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LOW_W       = 16,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              readyN,
  input  ctrlCmd_t          cmd,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic [ADDR_W-1:0] addrCur,
  output dpStat_t           stat
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cntReg;
  logic              wideReg;
  logic [LOW_W:0]    lowSum;
  logic [ADDR_W-1:0] step;
  logic [SYNC_STAGES-1:0] syncQ;

  // width is sampled while reset is held, frozen once released
  always_ff @(posedge clk) begin
    if (!rstN) wideReg <= busWide;
  end

  assign step   = wideReg ? ADDR_W'(2) : ADDR_W'(1);
  assign lowSum = {1'b0, addrReg[LOW_W-1:0]} + (LOW_W+1)'(step);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      cntReg  <= '0;
    end else if (cmd.load) begin
      addrReg <= startAddr;
      cntReg  <= wordCount;
    end else if (cmd.advance) begin
      addrReg <= addrReg + step;
      cntReg  <= cntReg - CNT_W'(1);
    end
  end

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b1;
        else if (g == 0) syncQ[g] <= readyN;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign addrCur        = addrReg;
  assign stat.lastWord  = (cntReg == CNT_W'(1));
  assign stat.crossLow  = lowSum[LOW_W];
  assign stat.readyOk   = ~syncQ[LAST];
  assign stat.countZero = (wordCount == '0);

  p_width_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> $stable(wideReg));
  p_count_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> cntReg == $past(cntReg) - CNT_W'(1));
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |=> addrReg - $past(addrReg) == (wideReg ? ADDR_W'(2) : ADDR_W'(1)));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     dirRead,
  input  dpStat_t  stat,
  output ctrlCmd_t cmd,
  output logic     readStrobeN,
  output logic     writeStrobeN,
  output logic     extLatch,
  output logic     busy,
  output logic     done
);
  tState_e state, stateNext;
  logic dirReg, doneReg, strobeOn;

  always_comb begin
    stateNext   = state;
    cmd.load    = 1'b0;
    cmd.advance = 1'b0;
    unique case (state)
      ST_IDLE: if (startReq && !stat.countZero) begin
        cmd.load  = 1'b1;
        stateNext = ST_XAL;
      end
      ST_XAL: stateNext = ST_T1;
      ST_T1:  stateNext = ST_T2;
      ST_T2, ST_TW: stateNext = stat.readyOk ? ST_T3 : ST_TW;
      ST_T3: begin
        cmd.advance = 1'b1;
        if (stat.lastWord)      stateNext = ST_IDLE;
        else if (stat.crossLow) stateNext = ST_XAL;
        else                    stateNext = ST_T1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      dirReg  <= 1'b0;
      doneReg <= 1'b0;
    end else begin
      state   <= stateNext;
      doneReg <= (state == ST_T3) && stat.lastWord;
      if (cmd.load) dirReg <= dirRead;
    end
  end

  assign strobeOn     = (state == ST_T2) || (state == ST_TW);
  assign readStrobeN  = ~(strobeOn && dirReg);
  assign writeStrobeN = ~(strobeOn && !dirReg);
  assign extLatch     = (state == ST_XAL);
  assign busy         = (state != ST_IDLE);
  assign done         = doneReg;

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!readStrobeN && !writeStrobeN));
  p_latch_then_setup_r2: assert property (@(posedge clk) disable iff (!rstN)
    extLatch |=> (state == ST_T1) && readStrobeN && writeStrobeN);
  p_wait_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !stat.readyOk) |=> (state == ST_TW) && $stable(readStrobeN) && $stable(writeStrobeN));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy);
  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |-> !cmd.load);
endmodule

// File: rtl/dma_cycle_seq.sv
module dma_cycle_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LOW_W      = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWide,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              dirRead,
  input  logic              readyN,
  output logic              readStrobeN,
  output logic              writeStrobeN,
  output logic [LOW_W-1:0]  addrLow,
  output logic [LOW_W-1:0]  addrHigh,
  output logic              extLatch,
  output logic              busy,
  output logic              done
);
  ctrlCmd_t          cmd;
  dpStat_t           stat;
  logic [ADDR_W-1:0] addrCur;

  dma_seq_datapath #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk(clk), .rstN(rstN), .busWide(busWide), .readyN(readyN), .cmd(cmd),
    .startAddr(startAddr), .wordCount(wordCount), .addrCur(addrCur), .stat(stat)
  );

  dma_seq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dirRead(dirRead), .stat(stat),
    .cmd(cmd), .readStrobeN(readStrobeN), .writeStrobeN(writeStrobeN),
    .extLatch(extLatch), .busy(busy), .done(done)
  );

  assign addrLow  = addrCur[LOW_W-1:0];
  assign addrHigh = addrCur[ADDR_W-1:LOW_W];

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> readStrobeN && writeStrobeN && !extLatch);
endmodule

// File: tb/dma_cycle_seq_test.sv
module dma_cycle_seq_test;
  logic clk = 0, rstN = 0, busWide = 1, startReq = 0, dirRead = 0, readyN = 1;
  logic [31:0] startAddr = '0;
  logic [15:0] wordCount = '0;
  logic readStrobeN, writeStrobeN, extLatch, busy, done;
  logic [15:0] addrLow, addrHigh;

  int errors = 0, checks = 0;
  bit curWide = 1, summaryDone = 0;

  always #2.5 clk = ~clk;

  dma_cycle_seq uut (
    .clk(clk), .rstN(rstN), .busWide(busWide), .startReq(startReq),
    .startAddr(startAddr), .wordCount(wordCount), .dirRead(dirRead),
    .readyN(readyN), .readStrobeN(readStrobeN), .writeStrobeN(writeStrobeN),
    .addrLow(addrLow), .addrHigh(addrHigh), .extLatch(extLatch),
    .busy(busy), .done(done)
  );

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] stepOf(bit wide);
    return wide ? 32'd2 : 32'd1;
  endfunction

  function automatic bit crosses(logic [31:0] a, bit wide);
    logic [16:0] s;
    s = {1'b0, a[15:0]} + 17'(stepOf(wide));
    return s[16];
  endfunction

  task automatic doReset(bit wide);
    busWide = wide;
    rstN = 0;
    repeat (4) @(negedge clk);
    check(readStrobeN && writeStrobeN && !extLatch && !done, "R1", "reset outputs",
          {readStrobeN, writeStrobeN, extLatch, done}, 4'b1100);
    rstN = 1;
    curWide = wide;
    @(negedge clk);
    busWide = ~wide; // R7: must not change the step
    check(readStrobeN && writeStrobeN && !extLatch && !done && !busy, "R1", "after release",
          {readStrobeN, writeStrobeN, extLatch, done}, 4'b1100);
    @(negedge clk);
  endtask

  task automatic runBlock(logic [31:0] addr, logic [15:0] cnt, bit rd, int waitW, bit inject);
    logic [31:0] expAddr;
    bit expXal, inStrobe, doneDue, dueNow, finished, injected;
    int words, len, guard, xals;
    readyN = (waitW == 0) ? 1'b0 : 1'b1;
    repeat (3) @(negedge clk);
    startAddr = addr; wordCount = cnt; dirRead = rd; startReq = 1;
    @(negedge clk);
    startReq = 0;
    if (cnt == 0) begin
      for (int i = 0; i < 12; i++) begin
        check(readStrobeN && writeStrobeN && !extLatch && !done && !busy, "R9",
              "zero count must stay idle", {readStrobeN, writeStrobeN, extLatch, done}, 4'b1100);
        @(negedge clk);
      end
      return;
    end
    expAddr = addr; expXal = 1; inStrobe = 0; doneDue = 0; finished = 0;
    injected = 0; words = 0; len = 0; guard = 0; xals = 0;
    while (!finished && guard < 2000) begin
      guard++;
      dueNow = doneDue; doneDue = 0;
      if (done) begin
        check(dueNow, "R8", "done timing", 32'(words), 32'(cnt));
        check(words == int'(cnt), "R8", "cycle count", 32'(words), 32'(cnt));
        finished = 1;
      end else if (dueNow) begin
        check(0, "R8", "done missing", 0, 1);
        finished = 1;
      end
      if (extLatch) begin
        xals++;
        check(expXal, (xals == 1) ? "R2" : "R6", "unexpected latch pulse", 1, 0);
        check(addrHigh == expAddr[31:16], (xals == 1) ? "R2" : "R6", "addrHigh at latch",
              32'(addrHigh), 32'(expAddr[31:16]));
        expXal = 0;
      end
      startReq = 0;
      if (!readStrobeN || !writeStrobeN) begin
        if (!inStrobe) begin
          check(!expXal, "R6", "strobe before latch pulse", 1, 0);
          check(addrLow == expAddr[15:0], "R5", "addrLow", 32'(addrLow), 32'(expAddr[15:0]));
          check(readStrobeN == !rd && writeStrobeN == rd, "R3", "strobe select",
                {readStrobeN, writeStrobeN}, {!rd, rd});
          inStrobe = 1; len = 0;
        end
        len++;
        if (waitW > 0 && len == waitW) readyN = 0;
        if (inject && !injected) begin
          startAddr = ~addr; wordCount = 16'd7; startReq = 1; injected = 1; // R9
        end
      end else if (inStrobe) begin
        check(len == ((waitW == 0) ? 1 : waitW + 2), (waitW == 0) ? "R3" : "R4",
              "strobe length", 32'(len), 32'((waitW == 0) ? 1 : waitW + 2));
        inStrobe = 0; words++;
        if (waitW > 0) readyN = 1;
        if (crosses(expAddr, curWide)) expXal = 1;
        expAddr = expAddr + stepOf(curWide);
        if (words == int'(cnt)) doneDue = 1;
      end
      if (!finished) @(negedge clk);
    end
    if (!finished) check(0, "R8", "block watchdog", 32'(words), 32'(cnt));
    @(negedge clk);
    check(!done && !busy && readStrobeN && writeStrobeN, "R8", "done single pulse",
          {done, busy}, 2'b00);
  endtask

  initial begin
    int cycles = 0;
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!summaryDone) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 150000);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    doReset(1);
    runBlock(32'h0001_FFFC, 16'd4, 1, 0, 0);   // R6 wide carry
    runBlock(32'h2000_0100, 16'd3, 0, 1, 0);   // R4 wait states, write
    runBlock(32'h3000_0010, 16'd1, 1, 3, 0);   // single word, long wait
    runBlock(32'h4000_0000, 16'd0, 1, 0, 0);   // R9 zero count
    runBlock(32'h5000_0040, 16'd4, 0, 0, 1);   // R9 start while busy
    doReset(0);
    runBlock(32'h1234_FFFE, 16'd3, 0, 2, 0);   // R5, R6 narrow carry, R7 frozen width
    runBlock(32'h0000_0000, 16'd5, 1, 0, 0);
    for (int i = 0; i < 12; i++) begin
      logic [31:0] a;
      a = $urandom;
      if (($urandom % 4) == 0) a[15:0] = 16'hFFFF - 16'($urandom % 6);
      runBlock(a, 16'(1 + ($urandom % 8)), 1'($urandom), int'($urandom % 4), 0);
      if (i == 5) doReset(1);
    end
    summaryDone = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule